// File: doc/BRIEF.md
# Page-Program Block-Erase Flash Store

This block is a synthesizable behavioural model of a nonvolatile array with flash write rules. It sits behind a small command port that takes an opcode, a block number and a page number. Page data moves as fixed-width beats over a write stream into the block and over a read stream out of it. The array is organised as `NUM_BLKS` blocks of `PAGES` pages. Each page holds `BEATS` beats of `BEAT_W` bits. The defaults are a scaled-down geometry of 32-bit pages, four pages per block and four blocks. All three counts must be powers of two.

A program operation gathers a whole page into a page buffer and then writes it into the array in one cycle. The write can only move cells from 1 to 0, so the stored page becomes the old contents ANDed with the new data. Bits return to 1 only through an erase, which clears a whole block at once. `busy` rises when a command is accepted, and the block ignores further commands until it finishes. Completion is marked by a single-cycle `done` pulse in the same cycle that `busy` returns low.

Both data streams use valid/ready. A beat moves on a clock edge where valid and ready are both high. While `rd_valid` is high and `rd_ready` is low, the block holds `rd_data` unchanged. The block raises `wr_ready` only while it is collecting program data. A source may leave `wr_valid` low for any number of cycles between beats.

Top module: `flash_page_store`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `wr_ready` are low, and every bit of every page reads as 1.
- R2: The block accepts a command on a clock edge where `busy` is low, `cmd_valid` is high and `cmd_op` is nonzero, and `busy` is high in the following cycle. Opcode encoding: 00 = no operation (ignored, `busy` stays low), 01 = read, 10 = program, 11 = erase.
- R3: The block ignores a command presented while `busy` is high. It has no effect on the array or on the running operation.
- R4: A read streams the addressed page as `BEATS` beats, beat 0 first, where beat k is page bits [k*BEAT_W +: BEAT_W]. `rd_valid` and `rd_data` hold steady while `rd_ready` is low, and `rd_valid` is never high in the same cycle as `wr_ready`.
- R5: A program takes `BEATS` beats in order over `wr_valid`/`wr_ready`. Each stored beat becomes its old value ANDed with the supplied beat, so no bit ever goes from 0 to 1.
- R6: An erase sets every bit of every page in the addressed block to 1 and leaves all other blocks unchanged.
- R7: `done` is a one-cycle pulse that appears only when `busy` is low. It comes 1 cycle after the last read beat transfers, 2 cycles after the last program beat transfers, and 2 cycles after an erase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; restores the erased array |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode (see R2) |
| cmd_blk | input | $clog2(NUM_BLKS) | Block number |
| cmd_page | input | $clog2(PAGES) | Page within block (ignored by erase) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | input | 1 | Program beat present |
| wr_ready | output | 1 | Block takes a program beat |
| wr_data | input | BEAT_W | Program beat |
| rd_valid | output | 1 | Read beat present |
| rd_ready | input | 1 | Sink takes a read beat |
| rd_data | output | BEAT_W | Read beat |

## Verification
`busy` is due in the cycle after the accepting edge. A read beat is compared on every cycle in which `rd_valid` is high, and it is only removed from the scoreboard on a cycle where `rd_ready` is also high. This makes a stalled beat that changes a miscompare. The bench records the time of the last read transfer and requires `done` exactly one clock later. For program and erase, it samples on the falling edges after the final write transfer or the accept and expects `done` on the second falling edge and low again on the third.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_COMMIT,
    ST_ERASE
  } flash_st_e;
endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
  parameter int BEATS    = 4,
  parameter int PAGES    = 4,
  parameter int NUM_BLKS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  input  logic [$clog2(PAGES)-1:0]    cmd_page,
  input  logic                        wr_valid,
  input  logic                        rd_ready,
  output logic                        busy,
  output logic                        done,
  output logic                        wr_ready,
  output logic                        rd_valid,
  output logic                        buf_we,
  output logic [$clog2(BEATS)-1:0]    beat_idx,
  output logic [$clog2(PAGES)-1:0]    page_sel,
  output logic [$clog2(NUM_BLKS)-1:0] blk_sel,
  output logic                        commit,
  output logic                        erase
);
  import flash_pkg::*;

  localparam int BEAT_AW = $clog2(BEATS);
  localparam int PG_AW   = $clog2(PAGES);
  localparam int BLK_AW  = $clog2(NUM_BLKS);

  flash_st_e           state_q;
  logic [BEAT_AW-1:0]  cnt_q;
  logic [PG_AW-1:0]    pg_q;
  logic [BLK_AW-1:0]   blk_q;
  logic                done_q;
  logic                last;
  logic                accept;

  assign last   = (cnt_q == BEAT_AW'(BEATS - 1));
  assign accept = (state_q == ST_IDLE) && cmd_valid && (cmd_op != OP_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pg_q    <= '0;
      blk_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            blk_q <= cmd_blk;
            pg_q  <= cmd_page;
            cnt_q <= '0;
            case (cmd_op)
              OP_READ: state_q <= ST_READ;
              OP_PROG: state_q <= ST_LOAD;
              default: state_q <= ST_ERASE;
            endcase
          end
        end
        ST_READ: begin
          if (rd_ready) begin
            if (last) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (wr_valid) begin
            if (last) begin
              cnt_q   <= '0;
              state_q <= ST_COMMIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_COMMIT, ST_ERASE: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_valid = (state_q == ST_READ);
  assign wr_ready = (state_q == ST_LOAD);
  assign buf_we   = (state_q == ST_LOAD) && wr_valid;
  assign beat_idx = cnt_q;
  assign page_sel = pg_q;
  assign blk_sel  = blk_q;
  assign commit   = (state_q == ST_COMMIT);
  assign erase    = (state_q == ST_ERASE);
endmodule

// File: rtl/flash_pagebuf.sv
module flash_pagebuf #(
  parameter int BEAT_W = 8,
  parameter int BEATS  = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(BEATS)-1:0] idx,
  input  logic [BEAT_W-1:0]        din,
  output logic [BEAT_W*BEATS-1:0]  page
);
  localparam int BEAT_AW = $clog2(BEATS);

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (we && idx == BEAT_AW'(b)) slot_q <= din;
    end
    assign page[b*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int BEAT_W   = 8,
  parameter int BEATS    = 4,
  parameter int PAGES    = 4,
  parameter int NUM_BLKS = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [$clog2(NUM_BLKS*PAGES*BEATS)-1:0]    rd_addr,
  output logic [BEAT_W-1:0]                          rd_data,
  input  logic                                       commit,
  input  logic [$clog2(NUM_BLKS*PAGES)-1:0]          commit_page,
  input  logic [BEAT_W*BEATS-1:0]                    commit_data,
  input  logic                                       erase,
  input  logic [$clog2(NUM_BLKS)-1:0]                erase_blk
);
  localparam int DEPTH      = NUM_BLKS * PAGES * BEATS;
  localparam int BLK_BEATS  = PAGES * BEATS;
  localparam int BLK_AW     = $clog2(NUM_BLKS);
  localparam int GPG_AW     = $clog2(NUM_BLKS * PAGES);

  logic [BEAT_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int MY_BLK  = g / BLK_BEATS;
    localparam int MY_PAGE = g / BEATS;
    localparam int MY_BEAT = g % BEATS;
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= '1;
      end else if (erase && erase_blk == BLK_AW'(MY_BLK)) begin
        mem[g] <= '1;
      end else if (commit && commit_page == GPG_AW'(MY_PAGE)) begin
        mem[g] <= mem[g] & commit_data[MY_BEAT*BEAT_W +: BEAT_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_page_store.sv
module flash_page_store #(
  parameter int BEAT_W   = 8,
  parameter int BEATS    = 4,
  parameter int PAGES    = 4,
  parameter int NUM_BLKS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  input  logic [$clog2(PAGES)-1:0]    cmd_page,
  output logic                        busy,
  output logic                        done,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [BEAT_W-1:0]           wr_data,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [BEAT_W-1:0]           rd_data
);
  localparam int BEAT_AW = $clog2(BEATS);
  localparam int PG_AW   = $clog2(PAGES);
  localparam int BLK_AW  = $clog2(NUM_BLKS);
  localparam int PAGE_W  = BEAT_W * BEATS;

  logic                buf_we;
  logic [BEAT_AW-1:0]  beat_idx;
  logic [PG_AW-1:0]    page_sel;
  logic [BLK_AW-1:0]   blk_sel;
  logic                commit;
  logic                erase;
  logic [PAGE_W-1:0]   buf_page;

  flash_ctrl #(.BEATS(BEATS), .PAGES(PAGES), .NUM_BLKS(NUM_BLKS)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .wr_valid(wr_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .buf_we(buf_we), .beat_idx(beat_idx), .page_sel(page_sel), .blk_sel(blk_sel),
    .commit(commit), .erase(erase)
  );

  flash_pagebuf #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_buf (
    .clk(clk), .we(buf_we), .idx(beat_idx), .din(wr_data), .page(buf_page)
  );

  flash_array #(.BEAT_W(BEAT_W), .BEATS(BEATS), .PAGES(PAGES), .NUM_BLKS(NUM_BLKS)) u_arr (
    .clk(clk), .rst(rst),
    .rd_addr({blk_sel, page_sel, beat_idx}), .rd_data(rd_data),
    .commit(commit), .commit_page({blk_sel, page_sel}), .commit_data(buf_page),
    .erase(erase), .erase_blk(blk_sel)
  );
endmodule

// File: rtl/flash_page_store_chk.sv
module flash_page_store_chk #(
  parameter int BEAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [BEAT_W-1:0] rd_data
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op != 2'b00) |=> busy);

  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd_valid && cmd_op != 2'b00)) |=> !busy);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_dir_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_ready));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

bind flash_page_store flash_page_store_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/flash_page_store_test.sv
module flash_page_store_test;
  localparam int BW = 8, BEATS = 4, PAGES = 4, BLKS = 4;
  localparam int CELLS = BLKS * PAGES * BEATS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cmd_valid, busy, done, wr_valid, wr_ready, rd_valid, rd_ready;
  logic [1:0] cmd_op, cmd_blk, cmd_page;
  logic [BW-1:0] wr_data, rd_data;

  flash_page_store #(.BEAT_W(BW), .BEATS(BEATS), .PAGES(PAGES), .NUM_BLKS(BLKS)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_page(cmd_page), .busy(busy), .done(done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  int vecs = 0, errs = 0;
  logic [BW-1:0] model [CELLS];
  logic [BW-1:0] expq [$];
  string tagq [$];
  bit stall_mode = 1'b0;
  time last_pop_t = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // read-ready driver, with optional back-pressure
  initial begin
    int phase = 0;
    rd_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      phase++;
      rd_ready = stall_mode ? (phase % 3 != 0) : 1'b1;
    end
  end

  // monitor: compare every presented beat, pop on transfer
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) chk(1'b0, "R4", "unexpected read beat", rd_data, 0);
      else begin
        chk(rd_data == expq[0], tagq[0], "read beat", rd_data, expq[0]);
        if (rd_ready) begin
          void'(expq.pop_front());
          void'(tagq.pop_front());
          last_pop_t = $time;
        end
      end
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [1:0] blk, input logic [1:0] pg);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk; cmd_page = pg;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
  endtask

  task automatic read_page(input logic [1:0] blk, input logic [1:0] pg, input string tag,
                           input bit inject, input logic [1:0] inj_blk);
    int n = 0;
    for (int b = 0; b < BEATS; b++) begin
      expq.push_back(model[blk*16 + pg*4 + b]);
      tagq.push_back(tag);
    end
    do_cmd(2'b01, blk, pg);
    if (inject) begin
      @(posedge clk); #2;
      cmd_valid = 1'b1; cmd_op = 2'b11; cmd_blk = inj_blk; cmd_page = 2'b00;
      @(posedge clk); #2;
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R3", "still busy with read after ignored erase", busy, 1);
    end
    do begin @(negedge clk); n++; end while (!done && n < 200);
    chk(done == 1'b1, "R7", "read done seen", done, 1);
    chk(busy == 1'b0, "R7", "busy low with read done", busy, 0);
    chk(($time - last_pop_t) == 20, "R7", "read done one cycle after last beat",
        32'($time - last_pop_t), 20);
    chk(expq.size() == 0, "R4", "all beats streamed", expq.size(), 0);
    expq.delete(); tagq.delete();
  endtask

  task automatic program_page(input logic [1:0] blk, input logic [1:0] pg,
                              input logic [31:0] data);
    for (int b = 0; b < BEATS; b++)
      model[blk*16 + pg*4 + b] = model[blk*16 + pg*4 + b] & data[b*8 +: 8];
    do_cmd(2'b10, blk, pg);
    for (int b = 0; b < BEATS; b++) begin
      @(posedge clk); #2;
      wr_valid = 1'b1; wr_data = data[b*8 +: 8];
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      @(posedge clk); #2;
      wr_valid = 1'b0;
    end
    @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, "R7", "program commit cycle", {busy, done}, 2'b10);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R7", "program done 2 cycles after last beat",
        {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0, "R7", "program done single pulse", done, 0);
  endtask

  task automatic erase_block(input logic [1:0] blk);
    for (int i = 0; i < 16; i++) model[blk*16 + i] = '1;
    do_cmd(2'b11, blk, 2'b00);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R7", "erase done 2 cycles after accept",
        {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0, "R7", "erase done single pulse", done, 0);
  endtask

  initial begin
    for (int i = 0; i < CELLS; i++) model[i] = '1;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_blk = 2'b00; cmd_page = 2'b00;
    wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk({busy, done, rd_valid, wr_ready} == 4'b0, "R1", "outputs idle after reset",
        {busy, done, rd_valid, wr_ready}, 0);

    // R1: erased contents after reset
    read_page(2'd0, 2'd0, "R1", 1'b0, 2'd0);
    read_page(2'd3, 2'd3, "R1", 1'b0, 2'd0);

    // R2: no-operation opcode is not accepted
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 2'b00;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2", "opcode 00 ignored", busy, 0);

    // R5: program then AND-accumulate
    program_page(2'd1, 2'd2, 32'h55AA_0FF0);
    read_page(2'd1, 2'd2, "R5", 1'b0, 2'd0);
    program_page(2'd1, 2'd2, 32'h00FF_3C3C);
    stall_mode = 1'b1;
    read_page(2'd1, 2'd2, "R4", 1'b0, 2'd0);   // back-pressure hold
    stall_mode = 1'b0;
    program_page(2'd1, 2'd2, 32'hFFFF_FFFF);   // cannot raise bits
    read_page(2'd1, 2'd2, "R5", 1'b0, 2'd0);
    program_page(2'd1, 2'd3, 32'h1234_5678);
    program_page(2'd2, 2'd0, 32'hDEAD_BEEF);

    // R3: erase issued during a read is ignored
    read_page(2'd1, 2'd3, "R3", 1'b1, 2'd1);
    read_page(2'd1, 2'd2, "R3", 1'b0, 2'd0);

    // R6: erase one block, neighbours intact
    erase_block(2'd1);
    read_page(2'd1, 2'd2, "R6", 1'b0, 2'd0);
    read_page(2'd1, 2'd3, "R6", 1'b0, 2'd0);
    read_page(2'd2, 2'd0, "R6", 1'b0, 2'd0);

    // R5: erased page programs cleanly again
    program_page(2'd1, 2'd2, 32'hA5C3_7E81);
    stall_mode = 1'b1;
    read_page(2'd1, 2'd2, "R5", 1'b0, 2'd0);
    stall_mode = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule